// File: doc/BRIEF.md
# Byte-Accessed Timer Compare Unit

The block is a 16-bit free-running timer that sits on an 8-bit processor bus. A prescaler steps the counter once every four clock cycles. Software loads a 16-bit compare value as two separate bytes. Each time the counter steps onto that value, the block raises a sticky compare flag. If the interrupt enable is on, the flag also drives an interrupt request. A capture pin is brought into the clock domain by a two-stage synchronizer. On its rising edge the block copies the counter into a capture register.

The two compare bytes have different roles. Writing the high byte suspends matching, and writing the low byte resumes it. This lets software load a new 16-bit value without a false match partway through the update. The low byte can also be rewritten on its own, and that write does not suspend matching. The flag is cleared in two steps: software reads the status register while the flag is set, then writes the compare low byte. Reset leaves the compare value and the flag as they were. The counter bytes are read through a latch, so the high and low bytes of one read always come from the same count.

Top module: `bytetimer`

## Requirements
- R1: While `rst_n` is low, the counter, the prescaler, the interrupt enable and the capture synchronizer are cleared. After release, the control register at 0x12 reads 0x00, `irq` is low and the counter reads 0.
- R2: The counter starts at 0 when reset is released and steps by one on every fourth rising clock edge. After n edges it reads floor(n/4) mod 65536. The counter high byte reads at 0x18 and the low byte at 0x19.
- R3: If matching is enabled, `cmp_flag` is set on the same edge at which the counter steps onto the value of the compare register. The flag is set only once per counter step. If the flag is cleared while the counter still holds the matching value, it stays clear.
- R4: `irq` is high exactly when `cmp_flag` is set and the enable bit is set. The enable is bit 6 of the control register at 0x12.
- R5: A write to the compare high byte (0x16) suspends matching. Matching stays suspended until the compare low byte (0x17) is written, and no flag is set in that interval. The low-byte write re-enables matching.
- R6: A write to the compare low byte alone does not suspend matching. A write to either compare byte leaves the other byte unchanged. Both compare bytes read back what was last written to them.
- R7: Reset does not change the compare register or the compare flag.
- R8: The status register at 0x13 reports the flag in bit 6 and 0 in its other bits. Reading it while the flag is set arms a clear, and the next write to 0x17 then clears the flag. A write to 0x17 that is not armed this way leaves the flag set.
- R9: Reading the counter high byte at 0x18 latches the low byte. A later read at 0x19 returns the latched byte and releases the latch. A 0x19 read with no latch pending returns the live low byte.
- R10: `cap_in` passes through two synchronizer flip-flops. A rising edge of the pin copies the counter into the capture register (high byte at 0x14, low byte at 0x15). If the pin rises just after edge k, the copy is taken at edge k+3 and holds the counter value from before that edge. A falling edge changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address while `bus_rd` is high |
| cap_in | input | 1 | Asynchronous capture pin |
| cmp_flag | output | 1 | Compare flag |
| irq | output | 1 | Compare interrupt request |

## Verification
Read data is combinational, so the bench samples it one time unit after driving a read, in the same cycle. Register writes take effect at the edge that ends the write cycle, and the bench checks them at the following falling edge. The bench keeps a count of edges since reset release, so the expected counter value is that count divided by four. The flag is expected at the edge that makes the count equal to four times the compare value, and the bench probes one cycle before that edge and at it. For capture, the expected value is the counter value two edges after the pin was raised, and the bench reads the capture register several cycles later, once the copy is complete.

// File: rtl/bytetimer_pkg.sv
package bytetimer_pkg;
  // register offsets; the capture and compare pairs keep their fixed layout
  localparam int unsigned ADR_CTRL   = 32'h12;
  localparam int unsigned ADR_STAT   = 32'h13;
  localparam int unsigned ADR_ICR_HI = 32'h14;
  localparam int unsigned ADR_ICR_LO = 32'h15;
  localparam int unsigned ADR_OCR_HI = 32'h16;
  localparam int unsigned ADR_OCR_LO = 32'h17;
  localparam int unsigned ADR_CNT_HI = 32'h18;
  localparam int unsigned ADR_CNT_LO = 32'h19;

  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned FLAG_BIT = 6;

  typedef struct packed {
    logic ctrl_wr;
    logic ocr_hi_wr;
    logic ocr_lo_wr;
    logic stat_rd;
    logic cnt_hi_rd;
    logic cnt_lo_rd;
  } bt_strobe_t;
endpackage

// File: rtl/bt_tick_counter.sv
module bt_tick_counter #(
  parameter int unsigned DIV   = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] presc_q, presc_d;

  always_comb begin
    tick    = (presc_q == PW'(DIV - 1));
    presc_d = tick ? '0 : presc_q + 1'b1;
    cnt_d   = tick ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/bt_capture.sv
module bt_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [CNT_W-1:0] cnt,
  output logic             cap_rise,
  output logic [CNT_W-1:0] icr_q
);
  logic             s1_q, s2_q, s3_q;
  logic [CNT_W-1:0] icr_d;

  always_comb begin
    cap_rise = s2_q & ~s3_q;
    icr_d    = cap_rise ? cnt : icr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // captured value is left alone by reset
  always_ff @(posedge clk) begin
    icr_q <= icr_d;
  end
endmodule

// File: rtl/bt_compare.sv
module bt_compare #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                stat_rd,
  input  logic                tick,
  input  logic [2*BYTE_W-1:0] cnt_d,
  output logic [2*BYTE_W-1:0] ocr_q,
  output logic                flag_q,
  output logic                inhibit_q
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] ocr_d;
  logic             flag_d, inhibit_d, arm_q, arm_d, match;

  always_comb begin
    ocr_d = ocr_q;
    if (wr_hi) ocr_d[CNT_W-1:BYTE_W] = wdata;
    if (wr_lo) ocr_d[BYTE_W-1:0]     = wdata;

    inhibit_d = inhibit_q;
    if (wr_hi)      inhibit_d = 1'b1;
    else if (wr_lo) inhibit_d = 1'b0;

    // evaluated only on the step that loads the counter
    match = tick && (cnt_d == ocr_q) && !inhibit_q;

    arm_d = arm_q;
    if (stat_rd && flag_q) arm_d = 1'b1;
    else if (wr_lo)        arm_d = 1'b0;

    flag_d = flag_q;
    if (match)               flag_d = 1'b1;
    else if (wr_lo && arm_q) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit_q <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      inhibit_q <= inhibit_d;
      arm_q     <= arm_d;
    end
  end

  // compare value and flag survive reset
  always_ff @(posedge clk) begin
    ocr_q  <= ocr_d;
    flag_q <= flag_d;
  end
endmodule

// File: rtl/bytetimer.sv
module bytetimer
  import bytetimer_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned PRESC_DIV = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cap_in,
  output logic              cmp_flag,
  output logic              irq
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  bt_strobe_t        strb;
  logic              tick, cap_rise, ocr_inhibit, wr_ocr_lo;
  logic [CNT_W-1:0]  cnt_q, cnt_d, icr_q, ocr_q;
  logic              ie_q, ie_d, lat_vld_q, lat_vld_d;
  logic [BYTE_W-1:0] lat_q, lat_d;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    strb           = '0;
    strb.ctrl_wr   = bus_wr && hit(bus_addr, ADR_CTRL);
    strb.ocr_hi_wr = bus_wr && hit(bus_addr, ADR_OCR_HI);
    strb.ocr_lo_wr = bus_wr && hit(bus_addr, ADR_OCR_LO);
    strb.stat_rd   = bus_rd && hit(bus_addr, ADR_STAT);
    strb.cnt_hi_rd = bus_rd && hit(bus_addr, ADR_CNT_HI);
    strb.cnt_lo_rd = bus_rd && hit(bus_addr, ADR_CNT_LO);
    wr_ocr_lo      = strb.ocr_lo_wr;
  end

  bt_tick_counter #(.DIV(PRESC_DIV), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  bt_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .cnt(cnt_q),
    .cap_rise(cap_rise), .icr_q(icr_q)
  );

  bt_compare #(.BYTE_W(BYTE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_hi(strb.ocr_hi_wr), .wr_lo(strb.ocr_lo_wr),
    .wdata(bus_wdata), .stat_rd(strb.stat_rd), .tick(tick), .cnt_d(cnt_d),
    .ocr_q(ocr_q), .flag_q(cmp_flag), .inhibit_q(ocr_inhibit)
  );

  // enable bit and coherent counter read latch
  always_comb begin
    ie_d = strb.ctrl_wr ? bus_wdata[IE_BIT] : ie_q;
    lat_d     = lat_q;
    lat_vld_d = lat_vld_q;
    if (strb.cnt_hi_rd) begin
      lat_d     = cnt_q[BYTE_W-1:0];
      lat_vld_d = 1'b1;
    end else if (strb.cnt_lo_rd) begin
      lat_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      lat_vld_q <= 1'b0;
      lat_q     <= '0;
    end else begin
      ie_q      <= ie_d;
      lat_vld_q <= lat_vld_d;
      lat_q     <= lat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit(bus_addr, ADR_CTRL))        bus_rdata[IE_BIT]   = ie_q;
      else if (hit(bus_addr, ADR_STAT))   bus_rdata[FLAG_BIT] = cmp_flag;
      else if (hit(bus_addr, ADR_ICR_HI)) bus_rdata = icr_q[CNT_W-1:BYTE_W];
      else if (hit(bus_addr, ADR_ICR_LO)) bus_rdata = icr_q[BYTE_W-1:0];
      else if (hit(bus_addr, ADR_OCR_HI)) bus_rdata = ocr_q[CNT_W-1:BYTE_W];
      else if (hit(bus_addr, ADR_OCR_LO)) bus_rdata = ocr_q[BYTE_W-1:0];
      else if (hit(bus_addr, ADR_CNT_HI)) bus_rdata = cnt_q[CNT_W-1:BYTE_W];
      else if (hit(bus_addr, ADR_CNT_LO)) bus_rdata = lat_vld_q ? lat_q : cnt_q[BYTE_W-1:0];
    end
    irq = cmp_flag & ie_q;
  end
endmodule

// File: rtl/bytetimer_chk.sv
module bytetimer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cmp_flag,
  input logic             inhibit,
  input logic [CNT_W-1:0] icr_q,
  input logic             cap_rise,
  input logic             lo_wr
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  p_flag_on_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> (cnt_q != $past(cnt_q)));

  p_no_match_inhibited_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inhibit) |-> !$rose(cmp_flag));

  p_clear_by_lo_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_flag) |-> $past(lo_wr));

  p_capture_only_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (icr_q != $past(icr_q)) |-> $past(cap_rise));

  p_capture_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_rise) |-> (icr_q == $past(cnt_q)));
endmodule

bind bytetimer bytetimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cmp_flag(cmp_flag),
  .inhibit(ocr_inhibit), .icr_q(icr_q), .cap_rise(cap_rise), .lo_wr(wr_ocr_lo)
);

// File: tb/bytetimer_test.sv
module bytetimer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h12, A_STAT = 8'h13, A_ICH = 8'h14, A_ICL = 8'h15,
                         A_OCH = 8'h16, A_OCL = 8'h17, A_CNH = 8'h18, A_CNL = 8'h19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, cap_in = 1'b0;
  logic [7:0] bus_rdata;
  logic       cmp_flag, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  bytetimer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cmp_flag(cmp_flag), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic [15:0] exp_cnt(input int n);
    return 16'(n / 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_flag(input logic [7:0] lo);
    logic [7:0] d;
    rd(A_STAT, d);
    wr(A_OCL, lo);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    logic [7:0]  d, h, l, a, b, c;
    logic [15:0] v;
    int          t;
    void'($urandom(32'd1357));
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 irq", irq, 1'b0);
    rd(A_CTRL, d); check("R1 ctrl", d, 8'h00);
    t = cyc; rd(A_CNH, h); rd(A_CNL, l);
    check("R1 counter", {h, l}, exp_cnt(t));

    // park compare far away and clear the flag
    wr(A_OCH, 8'hff); clear_flag(8'hff);
    check("R8 flag cleared", cmp_flag, 1'b0);

    // R2 / R9 counter reads
    for (int i = 0; i < 8; i++) begin
      repeat ($urandom % 16) @(negedge clk);
      t = cyc; rd(A_CNH, h);
      repeat ($urandom % 12) @(negedge clk);
      rd(A_CNL, l);
      check("R9 coherent read", {h, l}, exp_cnt(t));
      t = cyc; rd(A_CNL, l);
      check("R2 live low byte", l, exp_cnt(t) & 16'hff);
    end

    // R3 match timing and once-per-step
    v = exp_cnt(cyc) + 16'd5;
    wr(A_OCH, v[15:8]); wr(A_OCL, v[7:0]);
    wait_until(4 * v - 1);
    check("R3 before match", cmp_flag, 1'b0);
    @(negedge clk);
    check("R3 at match", cmp_flag, 1'b1);
    check("R4 irq masked", irq, 1'b0);
    rd(A_STAT, d); check("R8 status", d, 8'h40);
    wr(A_OCL, v[7:0]);
    check("R8 armed clear", cmp_flag, 1'b0);
    @(negedge clk);
    check("R3 no repeat while held", cmp_flag, 1'b0);

    // R4 / R8 unarmed write
    v = exp_cnt(cyc) + 16'd4;
    wr(A_OCH, v[15:8]); wr(A_OCL, v[7:0]);
    wait_until(4 * v);
    check("R3 second match", cmp_flag, 1'b1);
    wr(A_CTRL, 8'h40);
    check("R4 irq on", irq, 1'b1);
    wr(A_OCL, v[7:0]);
    check("R8 unarmed write keeps flag", cmp_flag, 1'b1);
    wr(A_CTRL, 8'h00);
    check("R4 irq off", irq, 1'b0);
    clear_flag(v[7:0]);
    check("R8 cleared", cmp_flag, 1'b0);

    // R5 inhibit after high byte write
    v = exp_cnt(cyc) + 16'd5;
    wr(A_OCH, v[15:8]); wr(A_OCL, v[7:0]); wr(A_OCH, v[15:8]);
    wait_until(4 * v + 2);
    check("R5 inhibited", cmp_flag, 1'b0);
    wr(A_OCL, v[7:0]);
    check("R5 still clear", cmp_flag, 1'b0);
    v = exp_cnt(cyc) + 16'd6;
    wr(A_OCH, v[15:8]);
    repeat (6) @(negedge clk);
    wr(A_OCL, v[7:0]);
    wait_until(4 * v);
    check("R5 re-enabled", cmp_flag, 1'b1);
    clear_flag(v[7:0]);

    // R6 low-only write keeps matching enabled
    v = exp_cnt(cyc) + 16'd6;
    wr(A_OCH, v[15:8]); wr(A_OCL, v[7:0] + 8'd100); wr(A_OCL, v[7:0]);
    wait_until(4 * v - 1);
    check("R6 before match", cmp_flag, 1'b0);
    @(negedge clk);
    check("R6 low-only match", cmp_flag, 1'b1);

    // R7 retention through reset
    do_reset();
    check("R7 flag kept", cmp_flag, 1'b1);
    check("R1 irq after reset", irq, 1'b0);
    rd(A_OCH, h); rd(A_OCL, l);
    check("R7 compare kept", {h, l}, v);
    rd(A_STAT, d); check("R7 status", d, 8'h40);
    t = cyc; rd(A_CNH, h); rd(A_CNL, l);
    check("R1 counter restarted", {h, l}, exp_cnt(t));

    // R6 byte independence, random values
    for (int i = 0; i < 8; i++) begin
      a = 8'($urandom); b = 8'($urandom); c = 8'($urandom);
      wr(A_OCH, a); wr(A_OCL, b);
      rd(A_OCH, d); check("R6 high readback", d, a);
      rd(A_OCL, d); check("R6 low readback", d, b);
      wr(A_OCH, c);
      rd(A_OCL, d); check("R6 low unchanged", d, b);
      wr(A_OCL, a);
      rd(A_OCH, d); check("R6 high unchanged", d, c);
    end
    wr(A_OCH, 8'hff); wr(A_OCL, 8'hff);

    // R10 capture
    for (int i = 0; i < 5; i++) begin
      repeat ($urandom % 7) @(negedge clk);
      t = cyc; cap_in = 1'b1;
      repeat (6) @(negedge clk);
      rd(A_ICH, h); rd(A_ICL, l);
      check("R10 capture value", {h, l}, exp_cnt(t + 2));
      cap_in = 1'b0;
      repeat (8) @(negedge clk);
      rd(A_ICH, a); rd(A_ICL, b);
      check("R10 falling edge ignored", {a, b}, {h, l});
    end

    finish_run();
  end
endmodule